// File: doc/BRIEF.md
# TDM Antenna Switch Sequencer

This block drives the switch control lines of a radar front-end that carries a 16-way receive antenna switch and a 4-way transmit antenna switch. A chirp synchronisation pulse arrives from the front-end. Its active edge marks the start of each chirp, and a nominal chirp lasts about 1 µs. On each chirp start the block applies the next transmit/receive channel pair from a host-programmed list, so the array works as a time-division MIMO radar with one pair per chirp.

The host fills a table of up to 64 entries through a simple write port. Each entry holds a 4-bit receive index and a 2-bit transmit index. The host also sets the index of the last active entry. A manual mode overrides the list with one fixed pair taken from host inputs. The block counts chirps and complete passes through the list (frames). It reports the table index in use and gives a one-cycle pulse when a chirp begins.

Top module: `tdm_switch_seq`

## Requirements
- R1: While rst_ni is low and after its release, before any chirp: rx_grp_o=1, rx_lo_o=0, rx_hi_o=0, tx_sel_o=0 (receive channel 1, transmit channel 1), chirp_cnt_o=0, frame_cnt_o=0, seq_idx_o=0, chirp_start_o=0.
- R2: A receive index r in 0..7 (channels 1 to 8) is driven as rx_grp_o=1, rx_hi_o=0, rx_lo_o=r.
- R3: A receive index r in 8..15 (channels 9 to 16) is driven as rx_grp_o=0, rx_lo_o=0, rx_hi_o=r-8.
- R4: A transmit index t in 0..3 (channels 1 to 4) is driven on tx_sel_o as t, bit 0 being the first line.
- R5: With fall_sel_i=0 a rising edge of sync_i starts a chirp, and with fall_sel_i=1 a falling edge does. The opposite edge changes neither the codes nor any counter.
- R6: Suppose sync_i takes its active edge before clock edge k. Then chirp_start_o is high for exactly the cycle after clock edge k+2, and the new switch codes appear at that same edge. Outside manual mode the codes stay unchanged at every other time.
- R7: In sequence mode each chirp start applies the table entry at the current pointer. The entry and its index show on seq_idx_o, and the pointer steps by one.
- R8: A chirp start that finds the pointer at or beyond seq_last_i applies that entry and returns the pointer to 0. Entry 0 applied after at least one earlier sequence chirp increments frame_cnt_o by one.
- R9: chirp_cnt_o increments by exactly one on every chirp start, in both modes.
- R10: While manual_i=1 the codes follow man_rx_i/man_tx_i one cycle later. Chirp starts leave seq_idx_o, frame_cnt_o and the pointer unchanged. After manual_i returns to 0, the next chirp resumes at the held pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Chirp synchronisation pulse (asynchronous) |
| fall_sel_i | input | 1 | 0: rising edge starts chirp, 1: falling edge |
| manual_i | input | 1 | Hold the fixed manual channel pair |
| man_rx_i | input | 4 | Manual receive index (0..15) |
| man_tx_i | input | 2 | Manual transmit index (0..3) |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 6 | Table write address |
| wr_rx_i | input | 4 | Receive index to write |
| wr_tx_i | input | 2 | Transmit index to write |
| seq_last_i | input | 6 | Index of the last active table entry |
| rx_lo_o | output | 3 | Receive lower select lines |
| rx_hi_o | output | 3 | Receive upper select lines |
| rx_grp_o | output | 1 | Receive group select |
| tx_sel_o | output | 2 | Transmit select lines |
| seq_idx_o | output | 6 | Table index currently applied |
| chirp_start_o | output | 1 | One-cycle pulse with each applied chirp |
| chirp_cnt_o | output | 16 | Chirp counter |
| frame_cnt_o | output | 16 | Frame counter |

## Verification
The bench sweeps all sixteen receive and four transmit indices through the table. A decoder that mixed up the two receive groups would put the index on the wrong three lines or leave the group bit wrong. Each chirp is timed edge by edge: a synchroniser with a missing or extra stage moves the start pulse and the new codes by one cycle, and the bench sees the shift. The opposite sync edge is applied in both polarity settings, which catches a detector that fires on both edges. Tables of one entry, sixteen entries, sixty-four entries and random lengths stress the wrap and frame count, including a last index lowered below the live pointer. Manual episodes check that the pointer holds and the chirp count goes on.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;
  localparam int RX_W = 4;
  localparam int TX_W = 2;
  localparam int GRP_W = RX_W - 1;

  typedef struct packed {
    logic [RX_W-1:0] rx;
    logic [TX_W-1:0] tx;
  } pair_t;

  typedef struct packed {
    logic [GRP_W-1:0] hi;
    logic [GRP_W-1:0] lo;
    logic             grp;
    logic [TX_W-1:0]  tx;
  } sw_code_t;

  localparam sw_code_t CODE_RST = '{hi: '0, lo: '0, grp: 1'b1, tx: '0};
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic fall_sel_i,
  output logic start_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= sync_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
    end
  end

  logic lvl, prv;
  assign lvl = sh_q[STAGES-1];
  assign prv = sh_q[STAGES];
  assign start_o = fall_sel_i ? (prv & ~lvl) : (lvl & ~prv);

  // R6
  single_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: rtl/seq_table.sv
module seq_table import tdm_seq_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  pair_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output pair_t         rdata_o
);
  pair_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sw_encoder.sv
module sw_encoder import tdm_seq_pkg::*; (
  input  pair_t    pair_i,
  output sw_code_t code_o
);
  always_comb begin
    code_o.tx = pair_i.tx;
    if (!pair_i.rx[RX_W-1]) begin
      code_o.grp = 1'b1;
      code_o.lo  = pair_i.rx[GRP_W-1:0];
      code_o.hi  = '0;
    end else begin
      code_o.grp = 1'b0;
      code_o.lo  = '0;
      code_o.hi  = pair_i.rx[GRP_W-1:0];
    end
  end
endmodule

// File: rtl/tdm_switch_seq.sv
module tdm_switch_seq import tdm_seq_pkg::*; #(
  parameter int DEPTH       = 64,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             fall_sel_i,
  input  logic             manual_i,
  input  logic [RX_W-1:0]  man_rx_i,
  input  logic [TX_W-1:0]  man_tx_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [RX_W-1:0]  wr_rx_i,
  input  logic [TX_W-1:0]  wr_tx_i,
  input  logic [AW-1:0]    seq_last_i,
  output logic [GRP_W-1:0] rx_lo_o,
  output logic [GRP_W-1:0] rx_hi_o,
  output logic             rx_grp_o,
  output logic [TX_W-1:0]  tx_sel_o,
  output logic [AW-1:0]    seq_idx_o,
  output logic             chirp_start_o,
  output logic [CNT_W-1:0] chirp_cnt_o,
  output logic [CNT_W-1:0] frame_cnt_o
);
  logic     start;
  logic     started_q;
  logic [AW-1:0] ptr_q, idx_q;
  logic [CNT_W-1:0] chirp_q, frame_q;
  logic     start_q;
  pair_t    entry, sel;
  sw_code_t code, code_q;

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .sync_i, .fall_sel_i, .start_o(start)
  );

  seq_table #(.DEPTH(DEPTH)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_addr_i),
    .wdata_i('{rx: wr_rx_i, tx: wr_tx_i}),
    .raddr_i(ptr_q), .rdata_o(entry)
  );

  assign sel = manual_i ? '{rx: man_rx_i, tx: man_tx_i} : entry;

  sw_encoder u_enc (.pair_i(sel), .code_o(code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q    <= CODE_RST;
      ptr_q     <= '0;
      idx_q     <= '0;
      started_q <= 1'b0;
      chirp_q   <= '0;
      frame_q   <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= start;
      if (manual_i || start) code_q <= code;
      if (start) chirp_q <= chirp_q + 1'b1;
      if (start && !manual_i) begin
        idx_q     <= ptr_q;
        started_q <= 1'b1;
        ptr_q     <= (ptr_q >= seq_last_i) ? '0 : ptr_q + 1'b1;
        if (ptr_q == '0 && started_q) frame_q <= frame_q + 1'b1;
      end
    end
  end

  assign rx_lo_o       = code_q.lo;
  assign rx_hi_o       = code_q.hi;
  assign rx_grp_o      = code_q.grp;
  assign tx_sel_o      = code_q.tx;
  assign seq_idx_o     = idx_q;
  assign chirp_start_o = start_q;
  assign chirp_cnt_o   = chirp_q;
  assign frame_cnt_o   = frame_q;

  // R2 R3
  grp_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grp_o ? (rx_hi_o == '0) : (rx_lo_o == '0));

  // R6
  codes_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chirp_start_o && !$past(manual_i)) |->
      ($stable(tx_sel_o) && $stable(rx_lo_o) && $stable(rx_hi_o) && $stable(rx_grp_o)));

  // R9
  chirp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chirp_start_o |-> chirp_cnt_o == $past(chirp_cnt_o) + 1'b1);

  // R9
  chirp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chirp_start_o |-> $stable(chirp_cnt_o));

  // R8
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_o != $past(frame_cnt_o)) |->
      (chirp_start_o && seq_idx_o == '0 && frame_cnt_o == $past(frame_cnt_o) + 1'b1));
endmodule

// File: tb/tdm_switch_seq_tb.sv
module tdm_switch_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sync, fall_sel, manual, wr_en;
  logic [3:0] man_rx, wr_rx;
  logic [1:0] man_tx, wr_tx;
  logic [5:0] wr_addr, seq_last;
  logic [2:0] rx_lo, rx_hi;
  logic rx_grp, chirp_start;
  logic [1:0] tx_sel;
  logic [5:0] seq_idx;
  logic [15:0] chirp_cnt, frame_cnt;

  tdm_switch_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .fall_sel_i(fall_sel),
    .manual_i(manual), .man_rx_i(man_rx), .man_tx_i(man_tx),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_rx_i(wr_rx), .wr_tx_i(wr_tx),
    .seq_last_i(seq_last), .rx_lo_o(rx_lo), .rx_hi_o(rx_hi), .rx_grp_o(rx_grp),
    .tx_sel_o(tx_sel), .seq_idx_o(seq_idx), .chirp_start_o(chirp_start),
    .chirp_cnt_o(chirp_cnt), .frame_cnt_o(frame_cnt)
  );

  int checks = 0, fails = 0;
  int m_rx[64], m_tx[64];
  int m_ptr = 0, m_idx = 0, m_frame = 0, m_chirp = 0, m_code = 4;
  bit m_started = 0;

  function automatic int enc(int rx, int tx);
    if (rx < 8) return (rx << 3) | 4 | tx;
    return ((rx - 8) << 6) | tx;
  endfunction

  function automatic int act_code();
    return int'({rx_hi, rx_lo, rx_grp, tx_sel});
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int rx, int tx);
    @(negedge clk);
    wr_en = 1; wr_addr = 6'(a); wr_rx = 4'(rx); wr_tx = 2'(tx);
    m_rx[a] = rx; m_tx[a] = tx;
    @(negedge clk);
    wr_en = 0;
  endtask

  // one chirp: active edge, timed checks, return edge must be ignored
  task automatic chirp();
    int idle = fall_sel ? 1 : 0;
    @(negedge clk);
    sync = ~idle[0];
    @(negedge clk);
    chk("R6 codes before k+2", act_code(), m_code);
    chk("R6 no early start", int'(chirp_start), 0);
    @(negedge clk);
    chk("R6 codes before k+2", act_code(), m_code);
    m_chirp++;
    if (!manual) begin
      m_idx = m_ptr;
      if (m_ptr == 0 && m_started) m_frame++;
      m_started = 1;
      m_code = enc(m_rx[m_ptr], m_tx[m_ptr]);
      m_ptr = (m_ptr >= int'(seq_last)) ? 0 : m_ptr + 1;
    end
    @(negedge clk);
    chk("R6 start pulse", int'(chirp_start), 1);
    chk(manual ? "R10 manual codes" : (m_rx[m_idx] < 8 ? "R2 R4 codes" : "R3 R4 codes"),
        act_code(), m_code);
    chk(manual ? "R10 index held" : "R7 seq index", int'(seq_idx), m_idx);
    chk(manual ? "R10 frame held" : "R8 frame count", int'(frame_cnt), m_frame);
    chk("R9 chirp count", int'(chirp_cnt), m_chirp);
    @(negedge clk);
    chk("R6 single pulse", int'(chirp_start), 0);
    repeat ($urandom_range(2, 5)) @(negedge clk);
    sync = idle[0];
    repeat (5) begin
      @(negedge clk);
      chk("R5 opposite edge no start", int'(chirp_start), 0);
    end
    chk("R5 opposite edge count", int'(chirp_cnt), m_chirp);
    chk("R5 opposite edge codes", act_code(), m_code);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin m_rx[i] = 0; m_tx[i] = 0; end
    rst_n = 0; sync = 0; fall_sel = 0; manual = 0; wr_en = 0;
    man_rx = 0; man_tx = 0; wr_rx = 0; wr_tx = 0; wr_addr = 0; seq_last = 15;
    repeat (3) @(negedge clk);
    chk("R1 reset codes", act_code(), enc(0, 0));
    chk("R1 reset chirp", int'(chirp_cnt), 0);
    chk("R1 reset frame", int'(frame_cnt), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 after release codes", act_code(), 4);
    chk("R1 after release index", int'(seq_idx), 0);
    chk("R1 after release start", int'(chirp_start), 0);

    // every receive and transmit index, rising edge
    for (int i = 0; i < 16; i++) wr(i, i, (i * 3) % 4);
    repeat (34) chirp();

    // falling edge polarity; rising edge while in that mode is ignored
    @(negedge clk); fall_sel = 1;
    @(negedge clk); sync = 1;
    repeat (6) @(negedge clk);
    chk("R5 rising ignored in falling mode", int'(chirp_cnt), m_chirp);
    chk("R5 rising ignored codes", act_code(), m_code);
    seq_last = 6'($urandom_range(1, 10));
    for (int i = 0; i <= int'(seq_last); i++) wr(i, $urandom_range(0, 15), $urandom_range(0, 3));
    repeat (2 * (int'(seq_last) + 1) + 3) chirp();

    // manual episodes
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      manual = 1; man_rx = 4'($urandom_range(0, 15)); man_tx = 2'($urandom_range(0, 3));
      m_code = enc(int'(man_rx), int'(man_tx));
      repeat (2) @(negedge clk);
      chk("R10 manual follow", act_code(), m_code);
      repeat (2) chirp();
      @(negedge clk);
      man_rx = 4'($urandom_range(0, 15)); man_tx = 2'($urandom_range(0, 3));
      m_code = enc(int'(man_rx), int'(man_tx));
      repeat (2) @(negedge clk);
      chk("R10 manual change", act_code(), m_code);
      chirp();
      @(negedge clk); manual = 0;
      repeat (2) @(negedge clk);
      chk("R10 held after exit", act_code(), m_code);
      chirp();
    end

    // back to rising edge: lowering sync is a falling edge, ignored
    @(negedge clk); fall_sel = 0;
    @(negedge clk); sync = 0;
    repeat (6) @(negedge clk);
    chk("R5 falling ignored in rising mode", int'(chirp_cnt), m_chirp);

    // full depth table
    seq_last = 63;
    for (int i = 0; i < 64; i++) wr(i, $urandom_range(0, 15), $urandom_range(0, 3));
    repeat (70) chirp();

    // last index lowered below live pointer, then single entry
    seq_last = 3;
    repeat (6) chirp();
    seq_last = 0;
    repeat (4) chirp();

    // random mix
    seq_last = 6'($urandom_range(0, 20));
    repeat (30) begin
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        manual = 1; man_rx = 4'($urandom_range(0, 15)); man_tx = 2'($urandom_range(0, 3));
        m_code = enc(int'(man_rx), int'(man_tx));
        chirp();
        @(negedge clk); manual = 0;
      end else begin
        chirp();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule